// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Registers and Sequencer

This block holds the register set and control sequencer of one bus-master disk DMA channel. Software reaches it through a byte-wide port with a 3-bit offset. The port holds a command byte, a status byte, two vendor bytes that always read as zero, and a 32-bit pointer to a table of transfer descriptors in memory. Software writes the pointer and the direction, issues the command to the drive, and then sets the run bit.

Once running, the sequencer reads descriptors from memory over a simple request/acknowledge read port. Each descriptor is two 32-bit words. It hands each buffer address and byte count, together with the direction, to an external data mover and waits until the mover reports completion. After the descriptor flagged as the last one has completed, the sequencer goes idle and raises the interrupt flag. A memory fault during a fetch raises the error flag. The drive's own interrupt line also raises the interrupt flag. Clearing the run bit abandons the transfer at once.

Top module: `bm_dma_regs`

## Requirements
- R1: Register reads by offset return the following. Offset 0 is the command byte: bit 0 is run, bit 3 is direction, and the other bits are zero. Offset 2 is the status byte. Offsets 4 to 7 are the table pointer, least significant byte at 4. Offsets 1 and 3 read zero and ignore writes. After reset every register reads zero.
- R2: Writing command bit 0 as 1 while it reads 0 sets status bit 0 (active). The sequencer then starts fetching at the table pointer.
- R3: A descriptor at address P has two words. The word at P is the buffer address. The word at P+4 holds the byte count in bits 15:0 and the end flag in bit 31. Descriptors are handed to the mover in table order at P, P+8, P+16 and so on. Each one is held on the mover port until the mover reports done.
- R4: When the descriptor with the end flag completes, status bit 0 clears and status bit 2 sets. The low three status bits then read 100b.
- R5: Writing command bit 0 as 0 clears status bit 0 on the next cycle and abandons the transfer without setting status bit 2.
- R6: A descriptor fetch that returns with the memory error flag sets status bit 1 and clears status bit 0.
- R7: Writing 1 to status bit 1 or status bit 2 clears that bit. Writing 0 to either bit leaves it unchanged.
- R8: Status bits 5 and 6 are plain read/write capability flags. Status bits 3 and 7 read zero.
- R9: While command bit 0 reads 1, writes to the direction bit and to the table pointer bytes are ignored.
- R10: The device interrupt input sets status bit 2. The irq output follows status bit 2.
- R11: The direction given to the mover equals command bit 3: 1 means device to memory, 0 means memory to device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_err | input | 1 | Read failed, valid with mem_ack |
| xfer_valid | output | 1 | Descriptor offered to the mover |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | LW | Buffer byte count |
| xfer_dir | output | 1 | 1 = device to memory |
| xfer_done | input | 1 | Mover finished the offered descriptor |
| dev_irq | input | 1 | Drive interrupt request |
| irq | output | 1 | Channel interrupt |

## Verification
The assertions assume the following about the inputs:
- mem_ack, mem_err and xfer_done only mean something while the matching request is raised.
- Software starts the engine only after it has issued the drive command, so dev_irq stays low during a descriptor walk.

The bench keeps within these assumptions. Its memory model acknowledges only raised requests. Its mover stub pulses done only while xfer_valid is high. It drives dev_irq only while the channel is idle. Stop and fault cases are reached through the register port and through a fault address in the memory model.

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_err,
  output logic          xfer_valid,
  output logic [31:0]   xfer_addr,
  output logic [LW-1:0] xfer_len,
  output logic          xfer_dir,
  input  logic          xfer_done,
  input  logic          dev_irq,
  output logic          irq
);
  localparam logic [31:0] ENT_BYTES = 32'd8;

  typedef enum logic [1:0] {S_IDLE, S_FADDR, S_FCNT, S_MOVE} st_t;
  st_t st;

  logic          cmd_run, cmd_dir, last_ent, sts_err, sts_irq;
  logic [1:0]    cap;
  logic [31:0]   tbl_ptr, cur_ptr, buf_addr;
  logic [LW-1:0] buf_len;

  logic wr_cmd, wr_sts, start, stop, fetch_err, end_evt, busy, unused_ok;

  assign wr_cmd    = reg_we && reg_addr == 3'd0;
  assign wr_sts    = reg_we && reg_addr == 3'd2;
  assign start     = wr_cmd && reg_wdata[0] && !cmd_run;
  assign stop      = wr_cmd && !reg_wdata[0];
  assign busy      = st != S_IDLE;
  assign mem_req   = st == S_FADDR || st == S_FCNT;
  assign mem_addr  = (st == S_FCNT) ? cur_ptr + 32'd4 : cur_ptr;
  assign fetch_err = mem_req && mem_ack && mem_err;
  assign end_evt   = st == S_MOVE && xfer_done && last_ent && !stop;
  assign xfer_valid = st == S_MOVE;
  assign xfer_addr = buf_addr;
  assign xfer_len  = buf_len;
  assign xfer_dir  = cmd_dir;
  assign irq       = sts_irq;
  assign unused_ok = ^mem_rdata[30:LW];

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {4'b0, cmd_dir, 2'b0, cmd_run};
      3'd2:    reg_rdata = {1'b0, cap, 2'b0, sts_irq, sts_err, busy};
      3'd4:    reg_rdata = tbl_ptr[7:0];
      3'd5:    reg_rdata = tbl_ptr[15:8];
      3'd6:    reg_rdata = tbl_ptr[23:16];
      3'd7:    reg_rdata = tbl_ptr[31:24];
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_run <= 1'b0;
      cmd_dir <= 1'b0;
      tbl_ptr <= '0;
      cap     <= '0;
      sts_err <= 1'b0;
      sts_irq <= 1'b0;
    end else begin
      if (wr_cmd) begin
        cmd_run <= reg_wdata[0];
        if (!cmd_run) cmd_dir <= reg_wdata[3];
      end
      if (reg_we && reg_addr[2] && !cmd_run)
        tbl_ptr[8*reg_addr[1:0] +: 8] <= reg_wdata;
      if (wr_sts) cap <= reg_wdata[6:5];
      sts_err <= fetch_err || (sts_err && !(wr_sts && reg_wdata[1]));
      sts_irq <= end_evt || dev_irq || (sts_irq && !(wr_sts && reg_wdata[2]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_ptr  <= '0;
      buf_addr <= '0;
      buf_len  <= '0;
      last_ent <= 1'b0;
    end else if (stop) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur_ptr <= tbl_ptr;
          st      <= S_FADDR;
        end
        S_FADDR: if (mem_ack) begin
          if (mem_err) st <= S_IDLE;
          else begin
            buf_addr <= mem_rdata;
            st       <= S_FCNT;
          end
        end
        S_FCNT: if (mem_ack) begin
          if (mem_err) st <= S_IDLE;
          else begin
            buf_len  <= mem_rdata[LW-1:0];
            last_ent <= mem_rdata[31];
            st       <= S_MOVE;
          end
        end
        S_MOVE: if (xfer_done) begin
          if (last_ent) st <= S_IDLE;
          else begin
            cur_ptr <= cur_ptr + ENT_BYTES;
            st      <= S_FADDR;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) start |=> busy);
  // R4
  end_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) end_evt |=> (sts_irq && !busy));
  // R5
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) stop |=> (!busy && !xfer_valid));
  // R6
  fetch_err_chk: assert property (@(posedge clk) disable iff (!rst_n) fetch_err |=> (sts_err && !busy));
  // R7
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && reg_wdata[2] && !dev_irq && !end_evt) |=> !sts_irq);
  // R9
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) cmd_run |=> ($stable(tbl_ptr) && $stable(cmd_dir)));
  // R10
  dev_irq_chk: assert property (@(posedge clk) disable iff (!rst_n) dev_irq |=> irq);
endmodule

// File: tb/tb_bm_dma_regs.sv
module tb_bm_dma_regs;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_ack, mem_err, xfer_valid, xfer_dir, dev_irq = 0, irq;
  logic [31:0] mem_addr, mem_rdata, xfer_addr;
  logic [15:0] xfer_len;
  logic xfer_done = 0, stall = 0;
  int errors = 0, checks = 0;
  logic [31:0] mem [0:63];
  logic [31:0] lg_addr [0:7];
  logic [15:0] lg_len [0:7];
  logic lg_dir [0:7];
  int lg_n = 0, cnt = 0;
  localparam logic [31:0] ERR_ADDR = 32'h88;

  always #4 clk = ~clk;

  bm_dma_regs dut (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req, .mem_addr, .mem_ack, .mem_rdata, .mem_err,
    .xfer_valid, .xfer_addr, .xfer_len, .xfer_dir, .xfer_done, .dev_irq, .irq);

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:2]];
  assign mem_err   = mem_req && mem_addr == ERR_ADDR;

  always @(posedge clk) begin
    if (xfer_valid && !xfer_done && !stall) begin
      cnt <= cnt + 1;
      if (cnt == 2) begin
        xfer_done <= 1;
        if (lg_n < 8) begin
          lg_addr[lg_n] <= xfer_addr; lg_len[lg_n] <= xfer_len; lg_dir[lg_n] <= xfer_dir;
        end
        lg_n <= lg_n + 1;
      end
    end else begin
      xfer_done <= 0; cnt <= 0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 300; i++) begin
      rd(3'd2, v);
      if (!v[0]) break;
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // {addr, wdata, expected readback}, engine stopped throughout
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'h08, 8'h08}, {3'd0, 8'h00, 8'h00},
    {3'd4, 8'h40, 8'h40}, {3'd5, 8'h00, 8'h00}, {3'd6, 8'h00, 8'h00}, {3'd7, 8'h00, 8'h00},
    {3'd1, 8'hff, 8'h00}, {3'd3, 8'hff, 8'h00},
    {3'd2, 8'h60, 8'h60}, {3'd2, 8'hff, 8'h60}, {3'd2, 8'h20, 8'h20}, {3'd2, 8'h00, 8'h00},
    {3'd0, 8'h08, 8'h08}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[16] = 32'h1000; mem[17] = 32'h200;
    mem[18] = 32'h2000; mem[19] = 32'h10;
    mem[20] = 32'h3000; mem[21] = 32'h8000_0004;
    mem[32] = 32'h5000; mem[33] = 32'h8;
    mem[40] = 32'h7000; mem[41] = 32'h40;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(3'd0, v); chk("R1 reset cmd", v, 8'h00);
    rd(3'd2, v); chk("R1 reset status", v, 8'h00);
    rd(3'd4, v); chk("R1 reset ptr", v, 8'h00);
    chk("R10 reset irq", irq, 0);

    // R1 R8 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk($sformatf("R1 R8 vector %0d", i), v, VEC[i][7:0]);
    end

    // R2 R3 R4 R11: three-entry chain at 0x40, device-to-memory
    wr(3'd0, 8'h09);
    rd(3'd2, v); chk("R2 active after start", v[0], 1);
    wait_idle();
    chk("R3 entry count", lg_n, 3);
    chk("R3 entry0 addr", lg_addr[0], 32'h1000); chk("R3 entry0 len", lg_len[0], 16'h200);
    chk("R3 entry1 addr", lg_addr[1], 32'h2000); chk("R3 entry1 len", lg_len[1], 16'h10);
    chk("R3 entry2 addr", lg_addr[2], 32'h3000); chk("R3 entry2 len", lg_len[2], 16'h4);
    chk("R11 dir read", lg_dir[2], 1);
    rd(3'd2, v); chk("R4 good completion", v[2:0], 3'b100);
    chk("R10 irq output", irq, 1);

    // R9 writes ignored while run set
    wr(3'd4, 8'h80); rd(3'd4, v); chk("R9 ptr locked", v, 8'h40);
    wr(3'd0, 8'h01); rd(3'd0, v); chk("R9 dir locked", v, 8'h09);
    // R7
    wr(3'd2, 8'h00); rd(3'd2, v); chk("R7 write zero keeps irq", v, 8'h04);
    wr(3'd2, 8'h04); rd(3'd2, v); chk("R7 irq cleared", v, 8'h00);
    wr(3'd0, 8'h00); rd(3'd0, v); chk("R9 dir kept on stop write", v, 8'h08);

    // R6 fetch fault on second entry, memory-to-device
    wr(3'd4, 8'h80);
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h01);
    wait_idle();
    chk("R6 entries before fault", lg_n, 4);
    chk("R11 dir write", lg_dir[3], 0);
    rd(3'd2, v); chk("R6 error status", v, 8'h02);
    wr(3'd2, 8'h04); rd(3'd2, v); chk("R7 irq write leaves err", v, 8'h02);
    wr(3'd2, 8'h02); rd(3'd2, v); chk("R7 err cleared", v, 8'h00);
    wr(3'd0, 8'h00);

    // R5 stop mid-transfer
    stall = 1;
    wr(3'd4, 8'hA0);
    wr(3'd0, 8'h01);
    repeat (6) @(negedge clk);
    chk("R3 mover offered", xfer_valid, 1);
    chk("R3 stop test addr", xfer_addr, 32'h7000);
    wr(3'd0, 8'h00);
    rd(3'd2, v); chk("R5 stopped no irq", v, 8'h00);
    chk("R5 mover released", xfer_valid, 0);
    stall = 0;
    repeat (5) @(negedge clk);
    chk("R5 no extra entry", lg_n, 4);

    // R10 device interrupt
    @(negedge clk); dev_irq = 1; @(negedge clk); dev_irq = 0;
    rd(3'd2, v); chk("R10 dev irq sets bit2", v, 8'h04);
    chk("R10 irq pin", irq, 1);
    wr(3'd2, 8'h04); chk("R10 irq pin cleared", irq, 0);

    summary();
  end
endmodule